// File: doc/BRIEF.md
# Dual-Mode Line Field Buffer

This block holds a field of pixels arranged as lines of words. Each word is split into a low half and a high half. A mode input selects how the field is reached. In streaming mode, a writer and a reader move through the field one word per cycle and one line after another. Each side has its own position. A line number that is shifted in one bit at a time sets the start line for either side.

In processor mode, a host uses two strobes on a shared address bus. A rising row strobe latches a line. A rising column strobe, while the row strobe is high, latches a start word and a half-select bit, then runs one 8-word burst. The burst reads or writes a 12-bit half-word on each beat.

A column strobe that rises while the row strobe is low is a host refresh cycle. It only advances a refresh row counter. In streaming mode, that counter advances by itself on a fixed period.

The default sizes are scaled down for simulation: 16 words per line, 6 lines, 24-bit words. The full-size field is 768 by 290.

Top module: `lfb_top`

## Requirements
- R1: After reset, `fr_valid`, `bvalid` and `rfsh_row` are 0, the mode is streaming, and both streaming sides point at line 0 word 0.
- R2: A streaming write (`fw_valid`=1) stores `fw_data[11:0]` into the low half when `lane_we[0]`=1 and `fw_data[23:12]` into the high half when `lane_we[1]`=1. A half that is not enabled keeps its old value. The write position advances on every write, even when `lane_we`=00.
- R3: A streaming read (`fr_en`=1) presents the 24-bit word at the read position on `fr_data` in the next cycle, with `fr_valid`=1 in that cycle only, and then advances the read position.
- R4: `sa_shift` shifts `sa_bit` into a line register, most significant bit first. `sa_load_w` or `sa_load_r` moves that value into the write or read side and sets its word to 0. A value of `LINES` or more loads line 0. A load takes priority over an advance in the same cycle.
- R5: After the last word of a line, a streaming position moves to word 0 of the next line. After the last line, it moves to line 0.
- R6: The write and read sides act in the same cycle without affecting each other. A read of the word being written in that cycle returns the old contents.
- R7: In processor mode, `baddr[2:0]` is latched as the line on a rising `ras`. A line of `LINES` or more becomes line 0. A rising `cas` while `ras` is high latches the start word from `baddr[3:0]` and starts a burst of 8 beats. Beat k uses word (start+k) mod `WORDS` in the same line.
- R8: A burst write (`b_we`=1 at the column strobe) stores `bdin` on each beat into the low half if `lane_we[0]`=1 and into the high half if `lane_we[1]`=1. The `bdin` value used is the one present at the edge after the previous beat.
- R9: In a burst read, `baddr[9]`=0 at the column strobe returns low halves and `baddr[9]`=1 returns high halves. `bvalid` is high for exactly 8 consecutive cycles, starting after the second clock edge that sees `cas` high.
- R10: In processor mode, a rising `cas` with `ras` low advances `rfsh_row` by one, modulo `LINES`. It produces no data output and no write.
- R11: In streaming mode, `rfsh_row` advances once every `RFSH_DIV` cycles. In processor mode it does not advance by itself.
- R12: When `blk_mode` changes, any burst stops (`bvalid` is 0 after that edge), both streaming sides return to line 0 word 0, and the latched line is cleared. A `ras` held high across the change starts nothing until it rises again.
- R13: The streaming inputs have no effect in processor mode. The strobes have no effect on data in streaming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_mode | input | 1 | 1 selects processor burst mode, 0 selects streaming mode |
| sa_bit | input | 1 | Serial line-number bit |
| sa_shift | input | 1 | Shift `sa_bit` into the line register |
| sa_load_w | input | 1 | Load the line register into the write side |
| sa_load_r | input | 1 | Load the line register into the read side |
| fw_valid | input | 1 | Streaming write strobe |
| lane_we | input | 2 | Half enables: bit 0 low, bit 1 high (both modes) |
| fw_data | input | 24 | Streaming write word |
| fr_en | input | 1 | Streaming read request |
| fr_valid | output | 1 | Streaming read data valid |
| fr_data | output | 24 | Streaming read word |
| ras | input | 1 | Row strobe |
| cas | input | 1 | Column strobe |
| b_we | input | 1 | Burst direction, 1 = write |
| baddr | input | ADDR_W (10) | Shared row/column address bus |
| bdin | input | 12 | Burst write half-word |
| bvalid | output | 1 | Burst read data valid |
| bdout | output | 12 | Burst read half-word |
| rfsh_row | output | $clog2(LINES) | Refresh row counter |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a burst, or while the row strobe is held high. The change must drop `bvalid` at once, return both streaming sides to line 0, and keep the held row strobe from starting a burst later. Directed sequences reach these cases: one switches modes three beats into a read burst, and another toggles the mode twice while `ras` stays high and then raises `cas`. A seeded random phase mixes reads, half-enabled writes and serial line loads on the streaming side, with line numbers beyond the last line, and is checked against a bench model of the array and pointers. Random bursts use start words near the end of a line to exercise the in-line wrap.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int unsigned HALF_W = 12;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } word_t;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_ROW   = 2'd1,
        BS_BURST = 2'd2
    } bst_t;

    // increment with wrap to zero at lim
    function automatic int unsigned step_wrap(int unsigned v, int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

    // out-of-range values collapse to zero
    function automatic int unsigned fit_or_zero(int unsigned v, int unsigned lim);
        return (v < lim) ? v : 0;
    endfunction

endpackage

// File: rtl/lfb_bank.sv
module lfb_bank #(
    parameter int unsigned DEPTH = 96,
    parameter int unsigned W     = 12,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [W-1:0]  rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/lfb_line_ptr.sv
module lfb_line_ptr
    import lfb_pkg::*;
#(
    parameter int unsigned LINES = 6,
    parameter int unsigned WORDS = 16,
    localparam int unsigned LA_W = $clog2(LINES),
    localparam int unsigned WA_W = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            load,
    input  logic [LA_W-1:0] load_line,
    input  logic            adv,
    output logic [LA_W-1:0] line,
    output logic [WA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            line <= '0;
            word <= '0;
        end else if (load) begin
            line <= load_line;
            word <= '0;
        end else if (adv) begin
            if (word == WA_W'(WORDS - 1)) begin
                word <= '0;
                line <= LA_W'(step_wrap(32'(line), LINES));
            end else begin
                word <= word + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lfb_burst.sv
module lfb_burst
    import lfb_pkg::*;
#(
    parameter int unsigned LINES  = 6,
    parameter int unsigned WORDS  = 16,
    parameter int unsigned BURST  = 8,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned LA_W  = $clog2(LINES),
    localparam int unsigned WA_W  = $clog2(WORDS),
    localparam int unsigned BC_W  = $clog2(BURST) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ras,
    input  logic              cas,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    output logic              act,
    output logic              act_wr,
    output logic [LA_W-1:0]   line,
    output logic [WA_W-1:0]   word,
    output logic              bank_hi,
    output logic              cbr
);
    logic            ras_q, cas_q, ras_rise, cas_rise;
    bst_t            st;
    logic [LA_W-1:0] row;
    logic [WA_W-1:0] col;
    logic [BC_W-1:0] beat;
    logic            dir, bsel;
    logic [WA_W:0]   sum;

    assign ras_rise = ras & ~ras_q;
    assign cas_rise = cas & ~cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b0;
            cas_q <= 1'b0;
            st    <= BS_IDLE;
            row   <= '0;
            col   <= '0;
            beat  <= '0;
            dir   <= 1'b0;
            bsel  <= 1'b0;
        end else begin
            ras_q <= ras;
            cas_q <= cas;
            if (!en) begin
                st   <= BS_IDLE;
                row  <= '0;
                col  <= '0;
                beat <= '0;
                dir  <= 1'b0;
                bsel <= 1'b0;
            end else begin
                case (st)
                    BS_IDLE: begin
                        if (ras_rise) begin
                            row <= LA_W'(fit_or_zero(32'(addr[LA_W-1:0]), LINES));
                            st  <= BS_ROW;
                        end
                    end
                    BS_ROW: begin
                        if (!ras) begin
                            st <= BS_IDLE;
                        end else if (cas_rise) begin
                            col  <= WA_W'(fit_or_zero(32'(addr[WA_W-1:0]), WORDS));
                            bsel <= addr[ADDR_W-1];
                            dir  <= wr_req;
                            beat <= '0;
                            st   <= BS_BURST;
                        end
                    end
                    BS_BURST: begin
                        if (beat == BC_W'(BURST - 1)) begin
                            beat <= '0;
                            st   <= ras ? BS_ROW : BS_IDLE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                    default: st <= BS_IDLE;
                endcase
            end
        end
    end

    // in-line wrap of the burst word address
    assign sum     = {1'b0, col} + (WA_W + 1)'(beat);
    assign word    = (sum >= (WA_W + 1)'(WORDS)) ? WA_W'(sum - (WA_W + 1)'(WORDS)) : WA_W'(sum);
    assign line    = row;
    assign act     = (st == BS_BURST);
    assign act_wr  = dir;
    assign bank_hi = bsel;
    assign cbr     = en & cas_rise & ~ras;
endmodule

// File: rtl/lfb_refresh.sv
module lfb_refresh
    import lfb_pkg::*;
#(
    parameter int unsigned LINES    = 6,
    parameter int unsigned RFSH_DIV = 16,
    localparam int unsigned LA_W    = $clog2(LINES),
    localparam int unsigned TW      = $clog2(RFSH_DIV)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            auto_en,
    input  logic            cbr,
    output logic [LA_W-1:0] row
);
    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = auto_en && (tmr == TW'(RFSH_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
            row <= '0;
        end else begin
            if (!auto_en || tick) tmr <= '0;
            else                  tmr <= tmr + 1'b1;
            if (tick || cbr) row <= LA_W'(step_wrap(32'(row), LINES));
        end
    end
endmodule

// File: rtl/lfb_top.sv
module lfb_top
    import lfb_pkg::*;
#(
    parameter int unsigned LINES    = 6,
    parameter int unsigned WORDS    = 16,
    parameter int unsigned BURST    = 8,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned RFSH_DIV = 16,
    localparam int unsigned LA_W    = $clog2(LINES),
    localparam int unsigned WA_W    = $clog2(WORDS),
    localparam int unsigned DEPTH   = LINES * WORDS,
    localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  blk_mode,
    input  logic                  sa_bit,
    input  logic                  sa_shift,
    input  logic                  sa_load_w,
    input  logic                  sa_load_r,
    input  logic                  fw_valid,
    input  logic [1:0]            lane_we,
    input  logic [2*HALF_W-1:0]   fw_data,
    input  logic                  fr_en,
    output logic                  fr_valid,
    output logic [2*HALF_W-1:0]   fr_data,
    input  logic                  ras,
    input  logic                  cas,
    input  logic                  b_we,
    input  logic [ADDR_W-1:0]     baddr,
    input  logic [HALF_W-1:0]     bdin,
    output logic                  bvalid,
    output logic [HALF_W-1:0]     bdout,
    output logic [LA_W-1:0]       rfsh_row
);
    logic            mode_q, sw, fifo_en, blk_en;
    logic [LA_W-1:0] shreg, load_val;
    logic [LA_W-1:0] w_line, r_line, b_line;
    logic [WA_W-1:0] w_word, r_word, b_word;
    logic            b_act, b_wr, b_hi, b_cbr;
    logic [IDX_W-1:0] fifo_widx, fifo_ridx, blk_idx;
    logic [HALF_W-1:0] rd_fifo [2];
    logic [HALF_W-1:0] rd_blk  [2];
    word_t           fr_word;

    // mode tracking: a differing input is a switch cycle, all traffic ignored
    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= blk_mode;
    end
    assign sw      = blk_mode ^ mode_q;
    assign fifo_en = ~mode_q & ~sw;
    assign blk_en  = mode_q & ~sw;

    // serial line number, msb first
    always_ff @(posedge clk) begin
        if (rst || sw)                shreg <= '0;
        else if (fifo_en && sa_shift) shreg <= LA_W'({shreg, sa_bit});
    end
    assign load_val = LA_W'(fit_or_zero(32'(shreg), LINES));

    lfb_line_ptr #(.LINES(LINES), .WORDS(WORDS)) u_wptr (
        .clk(clk), .rst(rst), .clr(sw),
        .load(fifo_en & sa_load_w), .load_line(load_val),
        .adv(fifo_en & fw_valid),
        .line(w_line), .word(w_word)
    );

    lfb_line_ptr #(.LINES(LINES), .WORDS(WORDS)) u_rptr (
        .clk(clk), .rst(rst), .clr(sw),
        .load(fifo_en & sa_load_r), .load_line(load_val),
        .adv(fifo_en & fr_en),
        .line(r_line), .word(r_word)
    );

    lfb_burst #(.LINES(LINES), .WORDS(WORDS), .BURST(BURST), .ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst(rst), .en(blk_en),
        .ras(ras), .cas(cas), .wr_req(b_we), .addr(baddr),
        .act(b_act), .act_wr(b_wr), .line(b_line), .word(b_word),
        .bank_hi(b_hi), .cbr(b_cbr)
    );

    lfb_refresh #(.LINES(LINES), .RFSH_DIV(RFSH_DIV)) u_rfsh (
        .clk(clk), .rst(rst), .auto_en(fifo_en), .cbr(b_cbr), .row(rfsh_row)
    );

    assign fifo_widx = IDX_W'(w_line) * IDX_W'(WORDS) + IDX_W'(w_word);
    assign fifo_ridx = IDX_W'(r_line) * IDX_W'(WORDS) + IDX_W'(r_word);
    assign blk_idx   = IDX_W'(b_line) * IDX_W'(WORDS) + IDX_W'(b_word);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic              we_h;
        logic [IDX_W-1:0]  widx_h;
        logic [HALF_W-1:0] wdat_h;

        always_comb begin
            if (fifo_en) begin
                we_h   = fw_valid & lane_we[h];
                widx_h = fifo_widx;
                wdat_h = fw_data[h*HALF_W +: HALF_W];
            end else begin
                we_h   = blk_en & b_act & b_wr & lane_we[h];
                widx_h = blk_idx;
                wdat_h = bdin;
            end
        end

        lfb_bank #(.DEPTH(DEPTH), .W(HALF_W)) u_bank (
            .clk(clk), .we(we_h), .widx(widx_h), .wdata(wdat_h),
            .ridx_a(fifo_ridx), .rdata_a(rd_fifo[h]),
            .ridx_b(blk_idx),   .rdata_b(rd_blk[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_valid <= 1'b0;
            fr_word  <= '0;
            bvalid   <= 1'b0;
            bdout    <= '0;
        end else begin
            fr_valid <= fifo_en & fr_en;
            if (fifo_en && fr_en) begin
                fr_word.hi <= rd_fifo[1];
                fr_word.lo <= rd_fifo[0];
            end
            bvalid <= blk_en & b_act & ~b_wr;
            if (blk_en && b_act && !b_wr) bdout <= b_hi ? rd_blk[1] : rd_blk[0];
        end
    end
    assign fr_data = fr_word;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
    parameter int unsigned LINES = 6,
    parameter int unsigned BURST = 8,
    localparam int unsigned LA_W = $clog2(LINES),
    localparam int unsigned CW   = $clog2(BURST) + 2
) (
    input logic            clk,
    input logic            rst,
    input logic            mode_q,
    input logic            fr_en,
    input logic            fr_valid,
    input logic            bvalid,
    input logic [LA_W-1:0] rfsh_row
);
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (bvalid) run <= run + 1'b1;
        else             run <= '0;
    end

    p_burst_len_r9: assert property (@(posedge clk) disable iff (rst)
        run <= CW'(BURST));

    p_read_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        fr_valid |-> $past(fr_en));

    p_refresh_step_r10: assert property (@(posedge clk) disable iff (rst)
        (rfsh_row != $past(rfsh_row)) |->
        (rfsh_row == (($past(rfsh_row) == LA_W'(LINES - 1)) ? '0 : $past(rfsh_row) + 1'b1)));

    p_switch_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> (!bvalid && !fr_valid));

    p_burst_only_block_r13: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> mode_q);

    p_no_stream_in_block_r13: assert property (@(posedge clk) disable iff (rst)
        (mode_q && $past(mode_q)) |-> !fr_valid);
endmodule

bind lfb_top lfb_checker #(.LINES(LINES), .BURST(BURST)) u_chk (
    .clk(clk), .rst(rst), .mode_q(mode_q), .fr_en(fr_en),
    .fr_valid(fr_valid), .bvalid(bvalid), .rfsh_row(rfsh_row)
);

// File: tb/sim_lfb_top.sv
module sim_lfb_top;
    localparam int L  = 6;
    localparam int W  = 16;
    localparam int LA = 3;
    localparam int NB = 8;
    localparam int RD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_mode = 1'b0;
    logic        sa_bit = 1'b0, sa_shift = 1'b0, sa_load_w = 1'b0, sa_load_r = 1'b0;
    logic        fw_valid = 1'b0;
    logic [1:0]  lane_we = 2'b00;
    logic [23:0] fw_data = '0;
    logic        fr_en = 1'b0;
    logic        fr_valid;
    logic [23:0] fr_data;
    logic        ras = 1'b0, cas = 1'b0, b_we = 1'b0;
    logic [9:0]  baddr = '0;
    logic [11:0] bdin = '0;
    logic        bvalid;
    logic [11:0] bdout;
    logic [2:0]  rfsh_row;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [11:0] mlo [L*W];
    logic [11:0] mhi [L*W];
    int wl = 0, ww = 0, rl = 0, rw = 0;

    always #2 clk = ~clk;

    lfb_top u0 (
        .clk(clk), .rst(rst), .blk_mode(blk_mode),
        .sa_bit(sa_bit), .sa_shift(sa_shift), .sa_load_w(sa_load_w), .sa_load_r(sa_load_r),
        .fw_valid(fw_valid), .lane_we(lane_we), .fw_data(fw_data),
        .fr_en(fr_en), .fr_valid(fr_valid), .fr_data(fr_data),
        .ras(ras), .cas(cas), .b_we(b_we), .baddr(baddr), .bdin(bdin),
        .bvalid(bvalid), .bdout(bdout), .rfsh_row(rfsh_row)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int fit(input int v, input int lim);
        return (v < lim) ? v : 0;
    endfunction

    task automatic adv(inout int l, inout int w);
        if (w == W - 1) begin
            w = 0;
            l = (l == L - 1) ? 0 : l + 1;
        end else begin
            w++;
        end
    endtask

    task automatic fstep(input bit wv, input logic [1:0] ln, input logic [23:0] wd,
                         input bit re, input string tag);
        int ridx, widx;
        logic [23:0] ex;
        fw_valid = wv; lane_we = ln; fw_data = wd; fr_en = re;
        ridx = rl * W + rw;
        ex = {mhi[ridx], mlo[ridx]};
        if (wv) begin
            widx = wl * W + ww;
            if (ln[0]) mlo[widx] = wd[11:0];
            if (ln[1]) mhi[widx] = wd[23:12];
            adv(wl, ww);
        end
        if (re) adv(rl, rw);
        @(negedge clk);
        fw_valid = 1'b0; fr_en = 1'b0;
        chk(fr_valid == re, tag, 32'(fr_valid), 32'(re));
        if (re) chk(fr_data == ex, tag, 32'(fr_data), 32'(ex));
    endtask

    task automatic sload(input int v, input bit rd_side);
        for (int i = LA - 1; i >= 0; i--) begin
            sa_bit = v[i];
            sa_shift = 1'b1;
            fstep(1'b0, 2'b00, 24'h0, 1'b0, "R4");
        end
        sa_shift = 1'b0;
        if (rd_side) sa_load_r = 1'b1; else sa_load_w = 1'b1;
        fstep(1'b0, 2'b00, 24'h0, 1'b0, "R4");
        sa_load_r = 1'b0; sa_load_w = 1'b0;
        if (rd_side) begin rl = fit(v, L); rw = 0; end
        else begin wl = fit(v, L); ww = 0; end
    endtask

    task automatic mswitch(input bit m);
        blk_mode = m;
        @(negedge clk);
        wl = 0; ww = 0; rl = 0; rw = 0;
    endtask

    task automatic bburst(input int row, input int col, input bit hi, input logic [1:0] lanes,
                          input bit wr, input string tag);
        int r, idx;
        logic [11:0] d, ex;
        ras = 1'b1; baddr = 10'(row);
        @(negedge clk);
        cas = 1'b1; b_we = wr; lane_we = lanes;
        baddr = {hi, 5'd0, 4'(col)};
        @(negedge clk);
        r = fit(row, L);
        for (int k = 0; k < NB; k++) begin
            d = 12'($urandom);
            bdin = d;
            idx = r * W + ((col + k) % W);
            ex = hi ? mhi[idx] : mlo[idx];
            if (wr) begin
                if (lanes[0]) mlo[idx] = d;
                if (lanes[1]) mhi[idx] = d;
            end
            @(negedge clk);
            chk(bvalid == !wr, tag, 32'(bvalid), 32'(!wr));
            if (!wr) chk(bdout == ex, tag, 32'(bdout), 32'(ex));
        end
        cas = 1'b0; ras = 1'b0; b_we = 1'b0; lane_we = 2'b00;
        @(negedge clk);
        chk(bvalid == 1'b0, "R9 burst length", 32'(bvalid), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++;
            vecs++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int r0;
        logic [23:0] wd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(fr_valid == 1'b0, "R1 fr_valid", 32'(fr_valid), 0);
        chk(bvalid == 1'b0, "R1 bvalid", 32'(bvalid), 0);
        chk(rfsh_row == 3'd0, "R1 rfsh_row", 32'(rfsh_row), 0);
        rst = 1'b0;
        @(negedge clk);

        // fill whole field from line 0 word 0, then read it all back (R1, R3, R5)
        for (int i = 0; i < L * W; i++) fstep(1'b1, 2'b11, 24'($urandom), 1'b0, "R5");
        chk(wl == 0 && ww == 0, "R5 model wrap", 32'(wl), 0);
        fstep(1'b0, 2'b00, 24'h0, 1'b1, "R1 first word");
        for (int i = 1; i < L * W; i++) fstep(1'b0, 2'b00, 24'h0, 1'b1, "R3 R5");

        // R2 directed half writes
        sload(2, 1'b0);
        sload(2, 1'b1);
        fstep(1'b1, 2'b11, 24'hABC123, 1'b0, "R2");
        sload(2, 1'b0);
        fstep(1'b1, 2'b01, 24'h555777, 1'b0, "R2");
        fstep(1'b1, 2'b10, 24'h999000, 1'b0, "R2");
        fstep(1'b1, 2'b00, 24'hFFFFFF, 1'b0, "R2");
        for (int i = 0; i < 4; i++) fstep(1'b0, 2'b00, 24'h0, 1'b1, "R2 half lanes");

        // R4 out-of-range line loads line 0
        sload(7, 1'b1);
        fstep(1'b0, 2'b00, 24'h0, 1'b1, "R4 clamp");

        // R6 same-address write and read in one cycle
        sload(4, 1'b0);
        sload(4, 1'b1);
        fstep(1'b1, 2'b11, 24'h0F0F0F, 1'b1, "R6 old data");
        fstep(1'b0, 2'b00, 24'h0, 1'b1, "R6");

        // random streaming traffic
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 19) == 0) sload(int'($urandom_range(0, 7)), 1'($urandom));
            wd = 24'($urandom);
            fstep(1'($urandom), 2'($urandom), wd, 1'($urandom), "R6 random");
        end

        // R11 auto refresh period
        r0 = int'(rfsh_row);
        repeat (3 * RD) @(negedge clk);
        chk(int'(rfsh_row) == (r0 + 3) % L, "R11 stream refresh", 32'(rfsh_row), 32'((r0 + 3) % L));

        // R13 strobes ignored in streaming mode
        ras = 1'b1; baddr = 10'd1; @(negedge clk);
        cas = 1'b1; @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(bvalid == 1'b0, "R13 strobes in stream", 32'(bvalid), 0);
        end
        ras = 1'b0; cas = 1'b0; @(negedge clk);

        // enter processor mode
        mswitch(1'b1);

        // R13 stream inputs ignored in processor mode
        for (int i = 0; i < 4; i++) begin
            fw_valid = 1'b1; lane_we = 2'b11; fw_data = 24'h123456; fr_en = 1'b1;
            @(negedge clk);
            chk(fr_valid == 1'b0, "R13 stream in block", 32'(fr_valid), 0);
        end
        fw_valid = 1'b0; fr_en = 1'b0; lane_we = 2'b00;
        bburst(0, 0, 1'b0, 2'b00, 1'b0, "R13 memory untouched lo");
        bburst(0, 0, 1'b1, 2'b00, 1'b0, "R13 memory untouched hi");

        // R7 R8 R9 directed wrap bursts
        bburst(3, 12, 1'b0, 2'b01, 1'b1, "R8 write lo");
        bburst(3, 12, 1'b0, 2'b00, 1'b0, "R7 wrap read lo");
        bburst(3, 12, 1'b1, 2'b00, 1'b0, "R9 read hi");
        bburst(7, 5, 1'b1, 2'b10, 1'b1, "R7 row clamp write");
        bburst(0, 5, 1'b1, 2'b00, 1'b0, "R7 row clamp read");

        // random bursts
        for (int i = 0; i < 30; i++) begin
            bburst(int'($urandom_range(0, 7)), int'($urandom_range(0, 15)), 1'($urandom),
                   2'($urandom), 1'($urandom), "R8 R9 random");
        end

        // R10 refresh cycle
        r0 = int'(rfsh_row);
        ras = 1'b0; cas = 1'b1; @(negedge clk);
        chk(bvalid == 1'b0, "R10 no data", 32'(bvalid), 0);
        chk(int'(rfsh_row) == (r0 + 1) % L, "R10 refresh step", 32'(rfsh_row), 32'((r0 + 1) % L));
        cas = 1'b0; @(negedge clk);
        // R11 no auto advance in processor mode
        r0 = int'(rfsh_row);
        repeat (3 * RD) @(negedge clk);
        chk(int'(rfsh_row) == r0, "R11 block hold", 32'(rfsh_row), 32'(r0));
        bburst(0, 0, 1'b0, 2'b00, 1'b0, "R10 memory unchanged");

        // R12 held ras across two switches starts nothing
        ras = 1'b1; baddr = 10'd2; @(negedge clk);
        mswitch(1'b0);
        mswitch(1'b1);
        cas = 1'b1; b_we = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(bvalid == 1'b0, "R12 row latch cleared", 32'(bvalid), 0);
        end
        cas = 1'b0; ras = 1'b0; @(negedge clk);

        // R12 abort a read burst midway
        ras = 1'b1; baddr = 10'd1; @(negedge clk);
        cas = 1'b1; baddr = 10'd0; @(negedge clk);
        repeat (3) @(negedge clk);
        chk(bvalid == 1'b1, "R12 burst running", 32'(bvalid), 1);
        mswitch(1'b0);
        chk(bvalid == 1'b0, "R12 abort", 32'(bvalid), 0);
        ras = 1'b0; cas = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(bvalid == 1'b0, "R12 stays quiet", 32'(bvalid), 0);
        end
        // streaming sides back at line 0 word 0
        fstep(1'b0, 2'b00, 24'h0, 1'b1, "R12 read pointer reset");
        fstep(1'b1, 2'b11, 24'h3C3C3C, 1'b0, "R12 write pointer reset");
        sload(0, 1'b1);
        fstep(1'b0, 2'b00, 24'h0, 1'b1, "R12 write landed at 0");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule